// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz time base, presented as a one-cycle enable tick in the system clock domain, into periodic interrupt events. A 4-bit rate code selects a power-of-two divide of the time base and a separate enable bit gates the events. Each event raises a periodic flag, a summary interrupt flag and the interrupt line. All three stay up until the status register is read, which the host signals with a one-cycle read strobe. Register decoding and timekeeping live elsewhere.

A free-running tick counter starts at zero on reset and never restarts. An event falls on the tick at which the counter reaches an exact multiple of the selected period, so the phase of the events is fixed by the counter and not by the moment the enable is set. The flag logic is a two-state machine. ST_QUIET is the state with no flags set. ST_RAISED is the state with all flags set. Three transitions are named:

- T_FIRE goes from ST_QUIET to ST_RAISED on an event.
- T_ACK goes from ST_RAISED to ST_QUIET on a read without an event.
- T_HOLD keeps ST_RAISED when a read and an event meet in the same cycle.

Top module: `pirq_rate_gen`

## Requirements
- R1: After reset pf_o, irqf_o and irq_o are 0 and the tick counter is 0.
- R2: Rate code 0 produces no events, whatever the enable bit.
- R3: With pie_en_i at 0 no event occurs for any rate code.
- R4: For rate codes 3 to 15 the period is 2^(code-1) ticks. An event occurs on the tick that brings the tick count since reset to a multiple of the period. The count wraps at 2^CNT_W.
- R5: Rate code 1 gives the same period as code 8 (128 ticks), and rate code 2 gives the same period as code 9 (256 ticks).
- R6: When the enable is set or the code is changed at an arbitrary count, the first event comes at the next multiple of the new period. It is not measured from the moment of the change.
- R7: An event sets pf_o, irqf_o and irq_o to 1 from the clock edge that samples the event tick.
- R8: A cycle with stat_rd_i at 1 and no event clears pf_o, irqf_o and irq_o at the next edge. Without a read the flags hold.
- R9: When an event and stat_rd_i fall in the same cycle, the event wins and all three outputs stay or become 1.
- R10: The counter advances only on cycles with tick32k_i at 1, and no event occurs on a cycle without a tick.
- R11: A change of the rate code or the enable takes effect at the next tick without resetting the tick counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick32k_i | input | 1 | One-cycle enable at the 32.768 kHz rate |
| rate_code_i | input | 4 | Rate select code (0 = off, 1 and 2 alias to 8 and 9) |
| pie_en_i | input | 1 | Periodic interrupt enable |
| stat_rd_i | input | 1 | Status register read strobe |
| pf_o | output | 1 | Periodic event flag |
| irqf_o | output | 1 | Summary interrupt flag |
| irq_o | output | 1 | Interrupt request line |

## Verification
The bench builds the block with the default counter width of 15 bits. This makes every period from 4 to 16384 ticks reachable, including the slowest code and the wrap of the counter. The tick is driven on every clock for most phases, so a full slowest period fits in about 16k cycles. One phase drives the tick every other clock to show that only ticks advance the phase. The phases with a rate change and with a late enable start at counts that are not period-aligned, which tests the alignment rule.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int unsigned CODE_W = 4;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } pirq_state_e;

    // Codes 1 and 2 select the slow rates of codes 8 and 9.
    function automatic logic [CODE_W-1:0] fold_code(input logic [CODE_W-1:0] c);
        logic [CODE_W-1:0] r;
        if (c == 4'd1)
            r = 4'd8;
        else if (c == 4'd2)
            r = 4'd9;
        else
            r = c;
        return r;
    endfunction

endpackage

// File: rtl/pirq_rate_decode.sv
module pirq_rate_decode
    import pirq_pkg::*;
#(
    parameter int unsigned CNT_W = 15
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              en_i,
    output logic              active_o,
    output logic [CNT_W-1:0]  mask_o
);

    logic [CODE_W-1:0] eff_code;

    always_comb begin
        eff_code = fold_code(code_i);
        active_o = en_i && (code_i != '0);
    end

    // Low (eff_code - 1) bits of the mask are set: period minus one.
    for (genvar g = 0; g < CNT_W; g++) begin : g_mask
        assign mask_o[g] = (int'(eff_code) > (g + 1));
    end

endmodule

// File: rtl/pirq_prescaler.sv
module pirq_prescaler #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] mask_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_nxt;

    always_comb begin
        count_nxt = count_q + {{(CNT_W-1){1'b0}}, 1'b1};
        hit_o     = tick_i && active_i && ((count_nxt & mask_i) == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (tick_i)
            count_q <= count_nxt;
    end

    assign count_o = count_q;

endmodule

// File: rtl/pirq_flag_fsm.sv
module pirq_flag_fsm
    import pirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic ack_i,
    output logic pf_o,
    output logic irqf_o,
    output logic irq_o
);

    pirq_state_e state_q;
    pirq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (fire_i)
                    state_d = ST_RAISED;          // T_FIRE
            end
            ST_RAISED: begin
                if (fire_i)
                    state_d = ST_RAISED;          // T_HOLD
                else if (ack_i)
                    state_d = ST_QUIET;           // T_ACK
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        pf_o   = 1'b0;
        irqf_o = 1'b0;
        irq_o  = 1'b0;
        unique case (state_q)
            ST_QUIET: ;
            ST_RAISED: begin
                pf_o   = 1'b1;
                irqf_o = 1'b1;
                irq_o  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pirq_rate_gen.sv
module pirq_rate_gen
    import pirq_pkg::*;
#(
    parameter int unsigned CNT_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick32k_i,
    input  logic [CODE_W-1:0] rate_code_i,
    input  logic              pie_en_i,
    input  logic              stat_rd_i,
    output logic              pf_o,
    output logic              irqf_o,
    output logic              irq_o
);

    logic             rate_active;
    logic [CNT_W-1:0] rate_mask;
    logic [CNT_W-1:0] tick_cnt;
    logic             period_hit;

    pirq_rate_decode #(.CNT_W(CNT_W)) u_decode (
        .code_i   (rate_code_i),
        .en_i     (pie_en_i),
        .active_o (rate_active),
        .mask_o   (rate_mask)
    );

    pirq_prescaler #(.CNT_W(CNT_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick32k_i),
        .active_i (rate_active),
        .mask_i   (rate_mask),
        .count_o  (tick_cnt),
        .hit_o    (period_hit)
    );

    pirq_flag_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (period_hit),
        .ack_i  (stat_rd_i),
        .pf_o   (pf_o),
        .irqf_o (irqf_o),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/pirq_rate_gen_chk.sv
module pirq_rate_gen_chk #(
    parameter int unsigned CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick32k_i,
    input logic [3:0]       rate_code_i,
    input logic             pie_en_i,
    input logic             stat_rd_i,
    input logic             pf_o,
    input logic             irqf_o,
    input logic             irq_o,
    input logic [CNT_W-1:0] tick_cnt
);

    function automatic logic [CNT_W-1:0] chk_mask(input logic [3:0] c);
        int unsigned e;
        logic [CNT_W-1:0] one;
        one = {{(CNT_W-1){1'b0}}, 1'b1};
        e = (c == 4'd1) ? 8 : (c == 4'd2) ? 9 : int'(c);
        return (one << (e - 1)) - one;
    endfunction

    // R1: the counter leaves reset at zero
    p_reset_zero_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (tick_cnt == '0 && !irq_o));

    p_rise_needs_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(rate_code_i) != 4'd0));

    p_rise_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(pie_en_i));

    p_period_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_o) |-> ((tick_cnt & chk_mask($past(rate_code_i))) == '0));

    p_flags_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_o == irq_o) && (irqf_o == irq_o));

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !tick32k_i) |=> !irq_o);

    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !stat_rd_i) |=> irq_o);

    p_rise_needs_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(tick32k_i));

    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && tick32k_i) |=> (tick_cnt == $past(tick_cnt) + 1'b1));

    p_count_still_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !tick32k_i) |=> $stable(tick_cnt));

endmodule

bind pirq_rate_gen pirq_rate_gen_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_pirq_rate_gen.sv
`timescale 1ns/1ps
module tb_pirq_rate_gen;

    localparam int unsigned CNT_W = 15;

    typedef struct {
        logic [2:0] val;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] code = 4'd0;
    logic       en = 1'b0;
    logic       rd = 1'b0;
    logic       pf, irqf, irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    exp_t q[$];

    logic [CNT_W-1:0] m_cnt = '0;
    logic             m_flag = 1'b0;

    always #10 clk = ~clk;

    pirq_rate_gen #(.CNT_W(CNT_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick32k_i   (tick),
        .rate_code_i (code),
        .pie_en_i    (en),
        .stat_rd_i   (rd),
        .pf_o        (pf),
        .irqf_o      (irqf),
        .irq_o       (irq)
    );

    task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one cycle of stimulus and the expected outputs after the next edge.
    task automatic step(input logic t, input logic [3:0] c, input logic e,
                        input logic r, input string tag);
        int unsigned eff;
        logic [CNT_W-1:0] nxt;
        logic [CNT_W-1:0] per_m1;
        logic evt;
        exp_t it;
        @(negedge clk);
        tick = t; code = c; en = e; rd = r;
        eff = (c == 4'd1) ? 8 : (c == 4'd2) ? 9 : int'(c);
        nxt = m_cnt + 1'b1;
        per_m1 = (eff == 0) ? '0 : CNT_W'((32'd1 << (eff - 1)) - 1);
        evt = t && e && (c != 4'd0) && ((nxt & per_m1) == '0);
        if (t) m_cnt = nxt;
        if (evt) m_flag = 1'b1;
        else if (r) m_flag = 1'b0;
        it.val = {m_flag, m_flag, m_flag};
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic run(input int n, input logic [3:0] c, input logic e,
                       input logic r, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, c, e, r, tag);
    endtask

    // Monitor: compares after every edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                check({pf, irqf, irq}, e.val, e.tag);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({pf, irqf, irq}, 3'b000, "R1 reset");
        rst_n = 1'b1;
        // R1: the first event of code 3 must land at count 4, proving a zero start
        run(8, 4'd3, 1'b1, 1'b1, "R1 first period");
        // R4 with R9: a read is held high, so each event meets a read
        run(40, 4'd3, 1'b1, 1'b1, "R4 code3");
        run(100, 4'd6, 1'b1, 1'b1, "R4 code6 R11");
        // R7 and R8: the flags hold without a read, then a lone read clears them
        run(70, 4'd5, 1'b1, 1'b0, "R7 hold");
        step(1'b0, 4'd5, 1'b1, 1'b1, "R8 read clears");
        step(1'b0, 4'd5, 1'b1, 1'b0, "R8 stays clear");
        // R2 and R3
        run(200, 4'd0, 1'b1, 1'b1, "R2 code0");
        run(150, 4'd3, 1'b0, 1'b1, "R3 disabled");
        // R6: enable at an unaligned count
        run(3, 4'd7, 1'b0, 1'b1, "R6 pre");
        run(200, 4'd7, 1'b1, 1'b1, "R6 align");
        // R5: aliased codes
        run(400, 4'd1, 1'b1, 1'b1, "R5 code1");
        run(600, 4'd2, 1'b1, 1'b1, "R5 code2");
        // R10: a tick on every other cycle only
        for (int i = 0; i < 120; i++) begin
            step(1'b1, 4'd4, 1'b1, 1'b1, "R10 tick");
            step(1'b0, 4'd4, 1'b1, 1'b1, "R10 idle");
        end
        // R11: a rate change in flight, with the counter untouched
        run(37, 4'd4, 1'b1, 1'b1, "R11 before");
        run(300, 4'd8, 1'b1, 1'b1, "R11 after");
        // R4: the slowest code across a counter wrap
        run(34000, 4'd15, 1'b1, 1'b1, "R4 code15 wrap");
        run(40, 4'd3, 1'b1, 1'b1, "R4 post wrap");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule